// File: doc/BRIEF.md
# PTP Receive Timestamp Qualifier

This block looks at the header fields that an upstream parser has already pulled out of a received frame and decides whether that frame is a PTP event message that should be timestamped. The inputs are the ethertype, an IPv4-present flag with the IP protocol byte, the UDP destination port, the PTP version nibble, and both the version-1 control byte and the version-2 message-type nibble. It emits at most one qualify pulse per frame, and the capture latch that holds the timestamp uses that pulse.

Host-written configuration arrives as three words. The receive control word carries an enable bit and a 3-bit stamping-mode code. The message selector word names the single message type to stamp. The ethertype filter word holds the layer-2 match value and two enable bits. In the single-message modes only the message type written in the selector is stamped. In the event mode any PTPv2 event message qualifies. A catch-all mode stamps every frame.

Top module: `ptp_rx_stamp_qual`

## Requirements
- R1: While rst_ni is low, qual_o is 0.
- R2: qual_o is high for exactly one cycle, in the cycle after a cycle with frame_valid_i high and a qualifying frame. With frame_valid_i low, qual_o is 0 in the next cycle.
- R3: With rx_ctrl_i[4] (enable) clear, no frame qualifies. rx_ctrl_i[0] has no effect on the decision.
- R4: Mode code rx_ctrl_i[3:1]=3'b100 qualifies every valid frame, whatever its header fields.
- R5: Mode code 3'b000 (layer-2 PTPv2) qualifies a frame only when all of the following hold: the layer-2 check passes, ptp_version_i is 2, and ptp_v2_type_i equals msg_sel_i[11:8]. The layer-2 check passes when ethertype_i equals etype_filt_i[15:0] and etype_filt_i bits 26 and 30 are both set. The host programs 0x88F7 into etype_filt_i[15:0].
- R6: If etype_filt_i bit 26 or bit 30 is clear, the layer-2 check fails.
- R7: Mode code 3'b001 (layer-4 PTPv1) qualifies a frame only when all of the following hold: ipv4_present_i is 1, ip_proto_i is 0x11, udp_dport_i is 319, ptp_version_i is 1, and ptp_v1_ctrl_i equals msg_sel_i[7:0]. The control codes are 0 Sync, 1 Delay_Req, 2 Follow_Up, 3 Delay_Resp and 4 Management.
- R8: Mode code 3'b010 qualifies a PTPv2 frame when either the layer-2 check or the layer-4 check passes and ptp_v2_type_i equals msg_sel_i[11:8].
- R9: Mode code 3'b101 (event) qualifies a frame when the layer-2 check passes, ptp_version_i is 2 and ptp_v2_type_i is 0 to 3 (Sync, Delay_Req, Pdelay_Req, Pdelay_Resp). msg_sel_i is ignored in this mode. Types such as 8 (Follow_Up) or 0xB (Announce) do not qualify.
- R10: Mode codes 3'b011, 3'b110 and 3'b111 qualify nothing.
- R11: A frame whose ptp_version_i differs from the version that the mode needs does not qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_ctrl_i | input | 5 | Receive control: [4] enable, [3:1] mode code, [0] unused |
| msg_sel_i | input | 16 | Message selector: [7:0] PTPv1 control code, [11:8] PTPv2 type |
| etype_filt_i | input | 32 | Ethertype filter: [15:0] value, [26] filter enable, [30] stamp enable |
| frame_valid_i | input | 1 | One-cycle strobe marking valid header fields |
| ethertype_i | input | 16 | Parsed ethertype |
| ipv4_present_i | input | 1 | An IPv4 header is present |
| ip_proto_i | input | 8 | IP protocol byte |
| udp_dport_i | input | 16 | UDP destination port |
| ptp_version_i | input | 4 | PTP version nibble |
| ptp_v1_ctrl_i | input | 8 | PTPv1 control field |
| ptp_v2_type_i | input | 4 | PTPv2 message type |
| qual_o | output | 1 | Timestamp qualify pulse |

## Verification
The assertions assume that every header field and configuration word is stable and meaningful in each cycle in which frame_valid_i is high. Each property relates the inputs sampled on such a strobe to qual_o one cycle later. The bench drives all fields, with the strobe, on the falling edge, holds the configuration fixed during each frame, and drops the strobe after one cycle. The expected decision therefore depends only on the values present at the sampling edge.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;
  localparam int ETYPE_W = 16;
  localparam int PORT_W  = 16;

  typedef enum logic [2:0] {
    SEL_L2_V2    = 3'b000,
    SEL_L4_V1    = 3'b001,
    SEL_ANY_V2   = 3'b010,
    SEL_ALL      = 3'b100,
    SEL_EVENT_V2 = 3'b101
  } stamp_sel_e;

  localparam int FILT_EN_BIT   = 26;
  localparam int FILT_TS_BIT   = 30;
  localparam int CTRL_EN_BIT   = 4;
  localparam logic [7:0] UDP_PROTO = 8'h11;
endpackage

// File: rtl/ptp_layer_match.sv
module ptp_layer_match
  import ptp_cls_pkg::*;
#(
  parameter int unsigned EVENT_PORT = 319
) (
  input  logic [ETYPE_W-1:0] ethertype_i,
  input  logic [31:0]        etype_filt_i,
  input  logic               ipv4_present_i,
  input  logic [7:0]         ip_proto_i,
  input  logic [PORT_W-1:0]  udp_dport_i,
  output logic               l2_hit_o,
  output logic               l4_hit_o
);
  localparam logic [PORT_W-1:0] PORT_VAL = PORT_W'(EVENT_PORT);

  logic unused_filt;
  assign unused_filt = ^{etype_filt_i[31], etype_filt_i[29:27], etype_filt_i[25:16]};

  assign l2_hit_o = etype_filt_i[FILT_EN_BIT] && etype_filt_i[FILT_TS_BIT] &&
                    (ethertype_i == etype_filt_i[ETYPE_W-1:0]);
  assign l4_hit_o = ipv4_present_i && (ip_proto_i == UDP_PROTO) &&
                    (udp_dport_i == PORT_VAL);
endmodule

// File: rtl/ptp_msg_match.sv
module ptp_msg_match (
  input  logic [3:0]  ptp_version_i,
  input  logic [7:0]  ptp_v1_ctrl_i,
  input  logic [3:0]  ptp_v2_type_i,
  input  logic [15:0] msg_sel_i,
  output logic        v1_hit_o,
  output logic        v2_hit_o,
  output logic        v2_event_o
);
  logic is_v1, is_v2;
  logic unused_sel;
  assign unused_sel = ^msg_sel_i[15:12];

  assign is_v1      = (ptp_version_i == 4'd1);
  assign is_v2      = (ptp_version_i == 4'd2);
  assign v1_hit_o   = is_v1 && (ptp_v1_ctrl_i == msg_sel_i[7:0]);
  assign v2_hit_o   = is_v2 && (ptp_v2_type_i == msg_sel_i[11:8]);
  // event class: types 0..3
  assign v2_event_o = is_v2 && (ptp_v2_type_i[3:2] == 2'b00);
endmodule

// File: rtl/ptp_rx_stamp_qual.sv
module ptp_rx_stamp_qual
  import ptp_cls_pkg::*;
#(
  parameter int unsigned EVENT_PORT = 319
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [4:0]         rx_ctrl_i,
  input  logic [15:0]        msg_sel_i,
  input  logic [31:0]        etype_filt_i,
  input  logic               frame_valid_i,
  input  logic [ETYPE_W-1:0] ethertype_i,
  input  logic               ipv4_present_i,
  input  logic [7:0]         ip_proto_i,
  input  logic [PORT_W-1:0]  udp_dport_i,
  input  logic [3:0]         ptp_version_i,
  input  logic [7:0]         ptp_v1_ctrl_i,
  input  logic [3:0]         ptp_v2_type_i,
  output logic               qual_o
);
  logic l2_hit, l4_hit, v1_hit, v2_hit, v2_event;
  logic hit, qual_q;
  stamp_sel_e sel;
  logic unused_ctrl;
  assign unused_ctrl = rx_ctrl_i[0];

  ptp_layer_match #(.EVENT_PORT(EVENT_PORT)) u_layer (
    .ethertype_i   (ethertype_i),
    .etype_filt_i  (etype_filt_i),
    .ipv4_present_i(ipv4_present_i),
    .ip_proto_i    (ip_proto_i),
    .udp_dport_i   (udp_dport_i),
    .l2_hit_o      (l2_hit),
    .l4_hit_o      (l4_hit)
  );

  ptp_msg_match u_msg (
    .ptp_version_i(ptp_version_i),
    .ptp_v1_ctrl_i(ptp_v1_ctrl_i),
    .ptp_v2_type_i(ptp_v2_type_i),
    .msg_sel_i    (msg_sel_i),
    .v1_hit_o     (v1_hit),
    .v2_hit_o     (v2_hit),
    .v2_event_o   (v2_event)
  );

  assign sel = stamp_sel_e'(rx_ctrl_i[3:1]);

  always_comb begin
    case (sel)
      SEL_L2_V2:    hit = l2_hit && v2_hit;
      SEL_L4_V1:    hit = l4_hit && v1_hit;
      SEL_ANY_V2:   hit = (l2_hit || l4_hit) && v2_hit;
      SEL_ALL:      hit = 1'b1;
      SEL_EVENT_V2: hit = l2_hit && v2_event;
      default:      hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_q <= 1'b0;
    else         qual_q <= frame_valid_i && rx_ctrl_i[CTRL_EN_BIT] && hit;
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/ptp_rx_stamp_qual_chk.sv
module ptp_rx_stamp_qual_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [4:0]  rx_ctrl_i,
  input logic [31:0] etype_filt_i,
  input logic        frame_valid_i,
  input logic [15:0] ethertype_i,
  input logic [7:0]  ip_proto_i,
  input logic [3:0]  ptp_version_i,
  input logic        qual_o
);
  p_reset_low_r1: assert property (@(posedge clk_i) !rst_ni |-> !qual_o);

  p_no_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !qual_o);

  p_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ctrl_i[4] |=> !qual_o);

  p_all_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && rx_ctrl_i[4] && rx_ctrl_i[3:1] == 3'b100) |=> qual_o);

  p_l2_etype_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ctrl_i[3:1] == 3'b000 && ethertype_i != etype_filt_i[15:0]) |=> !qual_o);

  p_filt_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ctrl_i[3:1] == 3'b101 && !(etype_filt_i[26] && etype_filt_i[30])) |=> !qual_o);

  p_l4_proto_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ctrl_i[3:1] == 3'b001 && ip_proto_i != 8'h11) |=> !qual_o);

  p_reserved_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ctrl_i[3:1] == 3'b011 || rx_ctrl_i[3:1] == 3'b110 || rx_ctrl_i[3:1] == 3'b111)
    |=> !qual_o);

  p_version_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ctrl_i[3:1] == 3'b001 && ptp_version_i != 4'd1) |=> !qual_o);
endmodule

bind ptp_rx_stamp_qual ptp_rx_stamp_qual_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_ctrl_i    (rx_ctrl_i),
  .etype_filt_i (etype_filt_i),
  .frame_valid_i(frame_valid_i),
  .ethertype_i  (ethertype_i),
  .ip_proto_i   (ip_proto_i),
  .ptp_version_i(ptp_version_i),
  .qual_o       (qual_o)
);

// File: tb/ptp_rx_stamp_qual_test.sv
`timescale 1ns/1ps
module ptp_rx_stamp_qual_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rx_ctrl = '0;
  logic [15:0] msg_sel = '0;
  logic [31:0] filt = '0;
  logic        fv = 1'b0;
  logic [15:0] etype = '0;
  logic        ipv4 = 1'b0;
  logic [7:0]  proto = '0;
  logic [15:0] dport = '0;
  logic [3:0]  ver = '0;
  logic [7:0]  v1c = '0;
  logic [3:0]  v2t = '0;
  logic        qual;
  int checks = 0;
  int fails = 0;

  localparam logic [31:0] FILT_ON = 32'h4400_88F7;

  always #5 clk = ~clk;

  ptp_rx_stamp_qual uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_ctrl_i(rx_ctrl), .msg_sel_i(msg_sel),
    .etype_filt_i(filt), .frame_valid_i(fv), .ethertype_i(etype),
    .ipv4_present_i(ipv4), .ip_proto_i(proto), .udp_dport_i(dport),
    .ptp_version_i(ver), .ptp_v1_ctrl_i(v1c), .ptp_v2_type_i(v2t), .qual_o(qual)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: qual_o=%0b expected %0b", req, act, exp);
    end
  endtask

  // one-cycle strobe; result sampled one cycle later, then must drop
  task automatic send(input logic exp, input string req);
    @(negedge clk); fv = 1'b1;
    @(negedge clk); fv = 1'b0;
    check(qual, exp, req);
    @(negedge clk);
    check(qual, 1'b0, {req, " R2 pulse width"});
  endtask

  task automatic l2_frame(input logic [3:0] t);
    etype = 16'h88F7; ipv4 = 1'b0; proto = 8'h00; dport = 16'd0;
    ver = 4'd2; v2t = t; v1c = 8'hFF;
  endtask

  task automatic l4_frame(input logic [3:0] v, input logic [7:0] c, input logic [3:0] t);
    etype = 16'h0800; ipv4 = 1'b1; proto = 8'h11; dport = 16'd319;
    ver = v; v1c = c; v2t = t;
  endtask

  task automatic t_reset;
    check(qual, 1'b0, "R1 in reset");
    rx_ctrl = 5'h18; fv = 1'b1;
    repeat (2) @(negedge clk);
    check(qual, 1'b0, "R1 strobe during reset");
    fv = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(qual, 1'b0, "R1 after release");
  endtask

  task automatic t_strobe_r2;
    rx_ctrl = 5'h18; fv = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(qual, 1'b0, "R2 no strobe");
    end
  endtask

  task automatic t_enable_r3;
    l2_frame(4'd0);
    rx_ctrl = 5'h08; send(1'b0, "R3 all mode disabled");
    filt = FILT_ON; msg_sel = 16'h0000;
    rx_ctrl = 5'h00; send(1'b0, "R3 l2 mode disabled");
    rx_ctrl = 5'h19; send(1'b1, "R3 bit0 ignored");
  endtask

  task automatic t_all_r4;
    rx_ctrl = 5'h18; filt = '0;
    etype = 16'h1234; ipv4 = 1'b0; ver = 4'd0; v2t = 4'hF;
    send(1'b1, "R4 arbitrary frame");
    l4_frame(4'd1, 8'd4, 4'd0);
    send(1'b1, "R4 udp frame");
  endtask

  task automatic t_l2_r5;
    rx_ctrl = 5'h10; filt = FILT_ON; msg_sel = 16'h0100;
    l2_frame(4'd1); send(1'b1, "R5 delay_req match");
    l2_frame(4'd0); send(1'b0, "R5 sync not selected");
    l2_frame(4'd1); etype = 16'h0800; send(1'b0, "R5 wrong ethertype");
    l4_frame(4'd2, 8'd0, 4'd1); send(1'b0, "R5 udp only frame");
  endtask

  task automatic t_filt_r6;
    rx_ctrl = 5'h10; msg_sel = 16'h0100; l2_frame(4'd1);
    filt = 32'h4000_88F7; send(1'b0, "R6 bit26 clear");
    filt = 32'h0400_88F7; send(1'b0, "R6 bit30 clear");
    filt = FILT_ON; send(1'b1, "R6 both set");
  endtask

  task automatic t_l4_r7;
    rx_ctrl = 5'h12; filt = FILT_ON; msg_sel = 16'h0001;
    l4_frame(4'd1, 8'd1, 4'd0); send(1'b1, "R7 v1 delay_req");
    l4_frame(4'd1, 8'd0, 4'd0); send(1'b0, "R7 v1 sync not selected");
    l4_frame(4'd1, 8'd1, 4'd0); dport = 16'd320; send(1'b0, "R7 port 320");
    l4_frame(4'd1, 8'd1, 4'd0); proto = 8'h06; send(1'b0, "R7 tcp");
    l4_frame(4'd1, 8'd1, 4'd0); ipv4 = 1'b0; send(1'b0, "R7 no ipv4");
    msg_sel = 16'h0000;
    l4_frame(4'd1, 8'd0, 4'd0); send(1'b1, "R7 v1 sync selected");
  endtask

  task automatic t_any_r8;
    rx_ctrl = 5'h14; filt = FILT_ON; msg_sel = 16'h0000;
    l4_frame(4'd2, 8'd0, 4'd0); send(1'b1, "R8 v2 sync over udp");
    l2_frame(4'd0); send(1'b1, "R8 v2 sync over l2");
    l2_frame(4'd1); send(1'b0, "R8 type not selected");
    l2_frame(4'd0); etype = 16'h0800; send(1'b0, "R8 neither layer");
  endtask

  task automatic t_event_r9;
    rx_ctrl = 5'h1A; filt = FILT_ON; msg_sel = 16'h0B00;
    for (int t = 0; t < 4; t++) begin
      l2_frame(4'(t)); send(1'b1, "R9 event type");
    end
    l2_frame(4'h8); send(1'b0, "R9 follow_up");
    l2_frame(4'hB); send(1'b0, "R9 announce");
    l4_frame(4'd2, 8'd0, 4'd0); send(1'b0, "R9 udp only");
  endtask

  task automatic t_reserved_r10;
    filt = FILT_ON; msg_sel = 16'h0000;
    l2_frame(4'd0); ipv4 = 1'b1; proto = 8'h11; dport = 16'd319;
    rx_ctrl = 5'h16; send(1'b0, "R10 code 011");
    rx_ctrl = 5'h1C; send(1'b0, "R10 code 110");
    rx_ctrl = 5'h1E; send(1'b0, "R10 code 111");
  endtask

  task automatic t_version_r11;
    filt = FILT_ON; msg_sel = 16'h0000;
    rx_ctrl = 5'h10; l2_frame(4'd0); ver = 4'd1; send(1'b0, "R11 v1 in l2 v2 mode");
    rx_ctrl = 5'h12; l4_frame(4'd2, 8'd0, 4'd0); send(1'b0, "R11 v2 in l4 v1 mode");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_strobe_r2();
    t_enable_r3();
    t_all_r4();
    t_l2_r5();
    t_filt_r6();
    t_l4_r7();
    t_any_r8();
    t_event_r9();
    t_reserved_r10();
    t_version_r11();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule